// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter with eight inputs. A start request latches a channel number and a clock-ratio selection. The block then steers the analog multiplexer to that channel and holds a sampling phase. After that it steps through one trial per result bit, from the most significant bit down. In each trial it drives a code to the external DAC and reads back the external comparator. When the last bit is settled, it publishes the 8-bit code and pulses a done flag and an interrupt request.

All phase lengths are counted in periods of a slower conversion clock. That clock is made inside the block by dividing the system clock by 2, 4, 8 or 16. Sampling takes 12 conversion-clock periods. Each of the eight bit trials takes 18 periods. A 4-period transfer window follows, so one conversion is always 160 periods long. The comparator, the DAC and the multiplexer sit outside the block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, busy_o, sample_o, done_o and irq_o are 0, and dac_o, result_o and mux_sel_o are all zero.
- R2: A start_i seen at a clock edge while idle is accepted. busy_o is 1 from the next cycle, and mux_sel_o shows the chan_i value from that edge until the next accepted start.
- R3: sample_o is 1 for exactly 12·N system cycles, beginning in the first busy cycle. N is the conversion-clock ratio.
- R4: Bit trial k (k = 0..7) lasts 18·N cycles. During it, dac_o holds the bits already settled, a 1 in bit 7−k and zeros below that. A comparator value cmp_i = 1 (input at or above dac_o) in the last cycle of the trial keeps bit 7−k; a 0 clears it. During sampling, dac_o is 00h.
- R5: The conversion ends 160·N cycles after acceptance. done_o is then high in the first cycle in which busy_o is low.
- R6: div_sel_i chooses N: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16. The value is latched when a start is accepted.
- R7: done_o and irq_o are both high for exactly one system cycle, in the cycle in which result_o first shows the new code. result_o then holds until the next conversion ends.
- R8: A start_i while busy_o is 1 is ignored. The channel, the ratio and the timing of the running conversion stay as they were, and this includes a start in the last busy cycle.
- R9: An input below the first DAC step gives result 00h, and an input at full scale gives FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| chan_i | input | 3 | Channel to convert, latched at start |
| div_sel_i | input | 2 | Conversion-clock ratio select, latched at start |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above dac_o |
| mux_sel_o | output | 3 | Analog multiplexer select |
| sample_o | output | 1 | Sampling phase active |
| dac_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-ready flag |
| irq_o | output | 1 | One-cycle interrupt request |
| result_o | output | 8 | Last conversion result |

## Verification
Two events can fall in the same cycle: the end of one conversion and the acceptance of the next. The bench drives start_i continuously through the last busy cycle and on into the done cycle. The request in the last busy cycle must be dropped. The request in the done cycle must begin a new conversion on the new channel at once. A behavioural model, written only in terms of elapsed cycles and the ratio, predicts every output on every clock. It also checks a start, a channel change and a ratio change applied in the middle of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_TRIAL  = 2'd2,
      PH_XFER   = 2'd3
   } sar_phase_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sar_clk_prescale.sv
module sar_clk_prescale #(
   parameter int SEL_W      = 2,
   parameter int FIXED_LOG2 = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int CNT_W = (FIXED_LOG2 > 0) ? FIXED_LOG2 : (1 << SEL_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("sar_clk_prescale: SEL_W out of range");
      end
      if (FIXED_LOG2 == 0) begin : g_selectable
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               last_q <= CNT_W'(1);
            else if (restart)
               last_q <= CNT_W'((32'd2 << sel) - 32'd1);
         end
      end else begin : g_fixed
         assign last_q = CNT_W'((1 << FIXED_LOG2) - 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (run)
         cnt_q <= (cnt_q == last_q) ? '0 : cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == last_q);

   // R6
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
   import sar_seq_pkg::*;
#(
   parameter int CH_W      = 3,
   parameter int SAMP_LEN  = 12,
   parameter int TRIAL_LEN = 18,
   parameter int XFER_LEN  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [CH_W-1:0] chan,
   input  logic            tick,
   input  logic            last_bit,
   output logic            accept,
   output logic            busy,
   output logic            sampling,
   output logic            samp_end,
   output logic            trial_end,
   output logic            xfer_end,
   output logic [CH_W-1:0] chan_sel
);
   localparam int MAXP  = max3(SAMP_LEN, TRIAL_LEN, XFER_LEN);
   localparam int CNT_W = $clog2(MAXP + 1);

   sar_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CH_W-1:0]  chan_q;
   logic             span_end;

   assign accept    = start && (phase_q == PH_IDLE);
   assign busy      = (phase_q != PH_IDLE);
   assign sampling  = (phase_q == PH_SAMPLE);
   assign span_end  = tick && busy && (cnt_q == '0);
   assign samp_end  = span_end && (phase_q == PH_SAMPLE);
   assign trial_end = span_end && (phase_q == PH_TRIAL);
   assign xfer_end  = span_end && (phase_q == PH_XFER);
   assign chan_sel  = chan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         chan_q  <= '0;
      end else if (accept) begin
         phase_q <= PH_SAMPLE;
         cnt_q   <= CNT_W'(SAMP_LEN - 1);
         chan_q  <= chan;
      end else if (tick && busy) begin
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            case (phase_q)
               PH_SAMPLE: begin
                  phase_q <= PH_TRIAL;
                  cnt_q   <= CNT_W'(TRIAL_LEN - 1);
               end
               PH_TRIAL: begin
                  if (last_bit) begin
                     phase_q <= PH_XFER;
                     cnt_q   <= CNT_W'(XFER_LEN - 1);
                  end else begin
                     cnt_q   <= CNT_W'(TRIAL_LEN - 1);
                  end
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   // R8
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(chan_q));

   // R3
   sample_to_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      samp_end |=> (phase_q == PH_TRIAL));

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            load_msb,
   input  logic            resolve,
   input  logic            commit,
   input  logic            cmp,
   output logic            last_bit,
   output logic [BITS-1:0] dac,
   output logic [BITS-1:0] result,
   output logic            done,
   output logic            irq
);
   localparam logic [BITS-1:0] MSB = {1'b1, {(BITS-1){1'b0}}};

   logic [BITS-1:0] probe_q, dac_q, res_q;
   logic            done_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         probe_q <= '0;
         dac_q   <= '0;
      end else if (clear) begin
         probe_q <= '0;
         dac_q   <= '0;
      end else if (load_msb) begin
         probe_q <= MSB;
         dac_q   <= MSB;
      end else if (resolve) begin
         dac_q   <= (cmp ? dac_q : (dac_q & ~probe_q)) | (probe_q >> 1);
         probe_q <= probe_q >> 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         done_q <= commit;
         irq_q  <= commit;
         if (commit)
            res_q <= dac_q;
      end
   end

   assign last_bit = probe_q[0];
   assign dac      = dac_q;
   assign result   = res_q;
   assign done     = done_q;
   assign irq      = irq_q;

   // R4
   probe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(probe_q));

   // R4
   bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resolve && !cmp |=> (dac_q & $past(probe_q)) == '0);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
   parameter int RES_BITS       = 8,
   parameter int CHANNELS       = 8,
   parameter int SAMPLE_PERIODS = 12,
   parameter int TOTAL_PERIODS  = 160,
   parameter int XFER_PERIODS   = 4,
   parameter int DIVSEL_W       = 2,
   parameter int FIXED_DIV_LOG2 = 0,
   localparam int CH_W          = $clog2(CHANNELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [CH_W-1:0]     chan_i,
   input  logic [DIVSEL_W-1:0] div_sel_i,
   input  logic                cmp_i,
   output logic [CH_W-1:0]     mux_sel_o,
   output logic                sample_o,
   output logic [RES_BITS-1:0] dac_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                irq_o,
   output logic [RES_BITS-1:0] result_o
);
   localparam int TRIAL_PERIODS =
      (TOTAL_PERIODS - SAMPLE_PERIODS - XFER_PERIODS) / RES_BITS;

   generate
      if (SAMPLE_PERIODS + RES_BITS * TRIAL_PERIODS + XFER_PERIODS != TOTAL_PERIODS)
      begin : g_bad_split
         $error("sar_seq_ctrl: trial periods do not divide evenly");
      end
      if (CHANNELS < 2 || RES_BITS < 2) begin : g_bad_size
         $error("sar_seq_ctrl: need at least 2 channels and 2 bits");
      end
   endgenerate

   logic tick, accept, samp_end, trial_end, xfer_end, last_bit;

   sar_clk_prescale #(
      .SEL_W(DIVSEL_W), .FIXED_LOG2(FIXED_DIV_LOG2)
   ) prescale_i (
      .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy_o),
      .sel(div_sel_i), .tick(tick)
   );

   sar_phase_seq #(
      .CH_W(CH_W), .SAMP_LEN(SAMPLE_PERIODS),
      .TRIAL_LEN(TRIAL_PERIODS), .XFER_LEN(XFER_PERIODS)
   ) phase_i (
      .clk(clk), .rst_n(rst_n), .start(start_i), .chan(chan_i),
      .tick(tick), .last_bit(last_bit), .accept(accept), .busy(busy_o),
      .sampling(sample_o), .samp_end(samp_end), .trial_end(trial_end),
      .xfer_end(xfer_end), .chan_sel(mux_sel_o)
   );

   sar_approx_reg #(
      .BITS(RES_BITS)
   ) approx_i (
      .clk(clk), .rst_n(rst_n), .clear(accept), .load_msb(samp_end),
      .resolve(trial_end), .commit(xfer_end), .cmp(cmp_i),
      .last_bit(last_bit), .dac(dac_o), .result(result_o),
      .done(done_o), .irq(irq_o)
   );

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);

   // R5
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && $past(busy_o));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

endmodule

// File: tb/sar_seq_ctrl_tb_top.sv
module sar_seq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] chan = '0;
   logic [1:0] dsel = '0;
   logic       cmp;
   logic [2:0] mux_sel;
   logic       sample, busy, done, irq;
   logic [7:0] dac, result;
   logic [7:0] ana [8];

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   sar_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
      .div_sel_i(dsel), .cmp_i(cmp), .mux_sel_o(mux_sel),
      .sample_o(sample), .dac_o(dac), .busy_o(busy), .done_o(done),
      .irq_o(irq), .result_o(result)
   );

   assign cmp = (ana[mux_sel] >= dac);

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // behavioural reference: elapsed cycles since acceptance
   bit m_busy, m_done;
   int m_t, m_n, m_chan, m_vin, m_res, m_hold;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_t = 0; m_n = 2;
         m_chan = 0; m_vin = 0; m_res = 0; m_hold = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_t++;
            if (m_t == 160 * m_n) begin
               m_busy = 0; m_done = 1; m_res = m_vin; m_hold = m_vin;
            end
         end else if (start) begin
            m_busy = 1; m_t = 0; m_chan = chan;
            m_n = 2 << dsel; m_vin = ana[chan];
         end
      end
   end

   function automatic int exp_dac();
      int p, i;
      if (!m_busy) return m_hold;
      p = m_t / m_n;
      if (p < 12) return 0;
      if (p < 156) begin
         i = (p - 12) / 18;
         return (m_vin & ((255 << (8 - i)) & 255)) | (1 << (7 - i));
      end
      return m_vin;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 busy", busy, m_busy);
         chk("R2 mux_sel", mux_sel, m_chan);
         chk("R3 sample", sample, (m_busy && (m_t / m_n) < 12) ? 1 : 0);
         chk("R4 dac", dac, exp_dac());
         chk("R7 done", done, m_done);
         chk("R7 irq", irq, m_done);
         chk("R7 result", result, m_res);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic pulse_start(input int ch, input int sel);
      @(negedge clk);
      start = 1'b1; chan = 3'(ch); dsel = 2'(sel);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic conv_latency(input int ch, input int sel, output int lat);
      @(negedge clk);
      start = 1'b1; chan = 3'(ch); dsel = 2'(sel);
      lat = 0;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      int lat;
      ana[0] = 8'h00; ana[1] = 8'h37; ana[2] = 8'h80; ana[3] = 8'hA5;
      ana[4] = 8'h7F; ana[5] = 8'h5A; ana[6] = 8'h01; ana[7] = 8'hFF;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 sample", sample, 0);
      chk("R1 done", done, 0);
      chk("R1 irq", irq, 0);
      chk("R1 dac", dac, 0);
      chk("R1 result", result, 0);
      chk("R1 mux_sel", mux_sel, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 R6 ratio 2, mid-scale code
      conv_latency(3, 0, lat);
      chk("R6 latency div2", lat, 160 * 2 + 1);
      chk("R5 result ch3", result, 8'hA5);
      chk("R5 busy low at done", busy, 0);

      // R9 zero input, ratio 4
      conv_latency(0, 1, lat);
      chk("R6 latency div4", lat, 160 * 4 + 1);
      chk("R9 zero code", result, 8'h00);

      // R9 full scale, ratio 16
      conv_latency(7, 3, lat);
      chk("R6 latency div16", lat, 160 * 16 + 1);
      chk("R9 full code", result, 8'hFF);

      // R8 start, channel and ratio change mid-conversion, ratio 8
      pulse_start(5, 2);
      repeat (300) @(negedge clk);
      start = 1'b1; chan = 3'd1; dsel = 2'd0;
      @(negedge clk);
      start = 1'b0;
      chk("R8 mux held", mux_sel, 5);
      lat = 302;
      while (!done) begin
         @(negedge clk);
         lat++;
      end
      chk("R8 latency kept", lat, 160 * 8 + 1);
      chk("R8 result of first channel", result, 8'h5A);

      // R8 R2 start through last busy cycle and into the done cycle
      pulse_start(2, 0);
      repeat (160 * 2 - 1) @(negedge clk);
      start = 1'b1; chan = 3'd6; dsel = 2'd0;
      chk("R8 still busy in last cycle", busy, 1);
      @(negedge clk);
      chk("R5 done cycle", done, 1);
      chk("R8 result unaffected", result, 8'h80);
      @(negedge clk);
      start = 1'b0;
      chk("R2 restart on done", busy, 1);
      chk("R2 new channel", mux_sel, 6);
      while (!done) @(negedge clk);
      chk("R4 one-LSB code", result, 8'h01);

      // R4 code 7Fh, ratio 2
      conv_latency(4, 0, lat);
      chk("R4 code 7F", result, 8'h7F);
      conv_latency(1, 0, lat);
      chk("R4 code 37", result, 8'h37);

      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule